// File: doc/BRIEF.md
# Mode-Selectable Bus Clock Prescaler

This block derives a bus clock enable from the main oscillator clock. The enable can run at the full clock rate, or at one half, one quarter, one eighth or one sixteenth of it. Downstream logic that runs on the main clock uses `bclk_en` to advance one bus cycle, so the bus period is always a whole number of main clock cycles. The CPU selects a ratio by writing a three-bit field. The block holds that request and applies it only when the current divided period ends. Because of this, no bus period is ever cut short or stretched to a length that belongs to neither the old mode nor the new one.

Reset selects divide-by-8 through an override bit in the request field. Entering stop mode sets the same override bit, so the clock always resumes at divide-by-8. Leaving divide-by-8 is held back while the oscillator-stable flag is low. The request stays pending until the flag goes high, and then it is applied at the next period boundary. The `eff_mode` output reports the ratio actually in force, never the pending request.

Top module: `sysclk_prescaler`

## Requirements
- R1: While `rst_n` is low at a rising edge, the effective mode becomes divide-by-8 (`eff_mode` = 3'b100) and `bclk_en` is low. After `rst_n` is first sampled high, `bclk_en` is first high in the cycle that follows the seventh rising edge.
- R2: The request code is decoded as follows. Bit 2 set selects divide-by-8, whatever bits 1:0 hold. Bit 2 clear uses bits 1:0: 00 is no division, 01 is /2, 10 is /4 and 11 is /16. In a divide-by-N mode, `bclk_en` is high for one cycle out of every N.
- R3: In no-division mode, `bclk_en` is high on every main clock cycle.
- R4: A request written with `mode_wr` high is captured at that rising edge. It takes effect only at the rising edge that ends a cycle in which `bclk_en` is high. The period in progress completes at its old length.
- R5: `eff_mode` shows the mode in use, using the R2 codes with divide-by-8 read as 3'b100. A request that is still pending does not change it.
- R6: `stop_req` sampled high sets the override bit in the held request. The block then moves to divide-by-8 at the next period boundary and stays there until a new write.
- R7: While the effective mode is divide-by-8 and `osc_stable` is low, a request for any other mode is not applied. It stays pending and is applied at the first period boundary at which `osc_stable` is high.
- R8: When `stop_req` and `mode_wr` are high in the same cycle, the stop override wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the requested mode |
| mode_sel | input | 3 | Requested mode code (bit 2 is the divide-by-8 override) |
| stop_req | input | 1 | Stop-mode entry; forces the override bit |
| osc_stable | input | 1 | Main oscillator has stabilised |
| bclk_en | output | 1 | Bus clock enable, one cycle per divided period |
| eff_mode | output | 3 | Code of the mode currently in effect |

## Verification
`bclk_en` comes combinationally from two registers: the divide counter and the effective mode. A write therefore changes the pulse spacing starting with the first full period after the next `bclk_en` cycle. The bench drives every input at a falling edge and samples at falling edges. It waits for one pulse after each stimulus and only then measures the spacing as a count of falling edges between pulses. `eff_mode` is checked on the falling edge after the boundary that applies the change. Pending values are checked on falling edges before that boundary. After reset release, the first pulse is counted from the falling edge at which `rst_n` was raised.

// File: rtl/prescaler_pkg.sv
// Shared types and decode helpers for the bus clock prescaler.
// Assumes the largest ratio is 2**DIV_LOG2_MAX (sixteen).
package prescaler_pkg;

    localparam int DIV_LOG2_MAX = 4;
    localparam int CODE_W       = 3;

    typedef enum logic [2:0] {
        MD_NODIV = 3'd0,
        MD_DIV2  = 3'd1,
        MD_DIV4  = 3'd2,
        MD_DIV8  = 3'd3,
        MD_DIV16 = 3'd4
    } div_mode_e;

    // Map a requested code onto a mode; the override bit wins over the field.
    function automatic div_mode_e decode_req(input logic [CODE_W-1:0] code);
        if (code[2]) return MD_DIV8;
        case (code[1:0])
            2'b00:   return MD_NODIV;
            2'b01:   return MD_DIV2;
            2'b10:   return MD_DIV4;
            default: return MD_DIV16;
        endcase
    endfunction

    // Code reported for a mode; divide-by-8 reports the override form.
    function automatic logic [CODE_W-1:0] encode_mode(input div_mode_e m);
        case (m)
            MD_NODIV: return 3'b000;
            MD_DIV2:  return 3'b001;
            MD_DIV4:  return 3'b010;
            MD_DIV16: return 3'b011;
            default:  return 3'b100;
        endcase
    endfunction

    // log2 of the division ratio for a mode.
    function automatic logic [2:0] ratio_log2(input div_mode_e m);
        case (m)
            MD_NODIV: return 3'd0;
            MD_DIV2:  return 3'd1;
            MD_DIV4:  return 3'd2;
            MD_DIV8:  return 3'd3;
            default:  return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/prescaler_req_reg.sv
// Holds the mode request written by the CPU.
// Assumes: reset and stop entry both set the divide-by-8 override bit;
// stop entry has priority over a write in the same cycle.
module prescaler_req_reg
    import prescaler_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_wr,
    input  logic [W-1:0] mode_sel,
    input  logic         stop_req,
    output logic [W-1:0] req_code
);

    localparam logic [W-1:0] OVERRIDE_CODE = W'(3'b100);

    // Capture writes; force the override on reset or stop entry.
    always_ff @(posedge clk) begin
        if (!rst_n)        req_code <= OVERRIDE_CODE;
        else if (stop_req) req_code <= OVERRIDE_CODE;
        else if (mode_wr)  req_code <= mode_sel;
    end

    assert_stop_sets_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> req_code[2]);

    assert_stop_beats_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && mode_wr && !mode_sel[2]) |=> req_code[2]);

endmodule

// File: rtl/prescaler_mode_ctrl.sv
// Keeps the effective mode and moves it to the requested mode only at a
// period boundary. Leaving divide-by-8 waits for a stable oscillator.
// Assumes 'boundary' is high in the last cycle of each divided period.
module prescaler_mode_ctrl
    import prescaler_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_code,
    input  logic         osc_stable,
    input  logic         boundary,
    output div_mode_e    eff_mode
);

    div_mode_e target;
    logic      exit_blocked;

    // Decode the held request and decide whether the switch is allowed.
    always_comb begin
        target       = decode_req(req_code);
        exit_blocked = (eff_mode == MD_DIV8) && (target != MD_DIV8) && !osc_stable;
    end

    // Update the mode in use only at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n)                         eff_mode <= MD_DIV8;
        else if (boundary && !exit_blocked) eff_mode <= target;
    end

    assert_reset_div8_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (eff_mode == MD_DIV8));

    assert_change_on_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(eff_mode));

    assert_hold_div8_unstable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode == MD_DIV8 && !osc_stable) |=> (eff_mode == MD_DIV8));

endmodule

// File: rtl/prescaler_divider.sv
// Divide counter: counts 0..N-1 for the current ratio and flags the last
// cycle of each period. Assumes the mode changes only while that flag is high.
module prescaler_divider
    import prescaler_pkg::*;
#(
    parameter int CNT_W = DIV_LOG2_MAX
) (
    input  logic      clk,
    input  logic      rst_n,
    input  div_mode_e mode,
    output logic      last_cyc
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   span_m1;
    logic [CNT_W-1:0] last_val;

    // Terminal count for the current ratio.
    always_comb begin
        span     = (CNT_W+1)'(1) << ratio_log2(mode);
        span_m1  = span - (CNT_W+1)'(1);
        last_val = span_m1[CNT_W-1:0];
        last_cyc = (cnt == last_val);
    end

    // Count up and wrap at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (last_cyc) cnt <= '0;
        else               cnt <= cnt + CNT_W'(1);
    end

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_val);

    assert_nodiv_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_NODIV) |-> last_cyc);

endmodule

// File: rtl/sysclk_prescaler.sv
// Top of the bus clock prescaler: request register, mode controller and
// divide counter. Assumes all inputs are synchronous to clk.
module sysclk_prescaler
    import prescaler_pkg::*;
#(
    parameter int CODE_BITS = CODE_W,
    parameter int CNT_BITS  = DIV_LOG2_MAX
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_wr,
    input  logic [CODE_BITS-1:0] mode_sel,
    input  logic                 stop_req,
    input  logic                 osc_stable,
    output logic                 bclk_en,
    output logic [CODE_BITS-1:0] eff_mode
);

    logic [CODE_BITS-1:0] req_code;
    div_mode_e            cur_mode;
    logic                 period_end;

    prescaler_req_reg #(.W(CODE_BITS)) u_req (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
        .stop_req(stop_req), .req_code(req_code)
    );

    prescaler_mode_ctrl #(.W(CODE_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_code(req_code), .osc_stable(osc_stable),
        .boundary(period_end), .eff_mode(cur_mode)
    );

    prescaler_divider #(.CNT_W(CNT_BITS)) u_div (
        .clk(clk), .rst_n(rst_n), .mode(cur_mode), .last_cyc(period_end)
    );

    // Drive the enable and report the mode in use.
    always_comb begin
        bclk_en  = period_end;
        eff_mode = CODE_BITS'(encode_mode(cur_mode));
    end

    assert_readback_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode[2] -> (eff_mode[1:0] == 2'b00)));

endmodule

// File: tb/tb_sysclk_prescaler.sv
module tb_sysclk_prescaler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic       stop_req = 1'b0;
    logic       osc_stable = 1'b1;
    logic       bclk_en;
    logic [2:0] eff_mode;

    int n_cmp = 0;
    int n_bad = 0;

    sysclk_prescaler dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
        .stop_req(stop_req), .osc_stable(osc_stable),
        .bclk_en(bclk_en), .eff_mode(eff_mode)
    );

    always #10ns clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!bclk_en);
    endtask

    task automatic gap(output int k);
        k = 0;
        do begin @(negedge clk); k++; end while (!bclk_en);
    endtask

    task automatic write_mode(input logic [2:0] code);
        mode_sel = code;
        mode_wr  = 1'b1;
        @(negedge clk);
        mode_wr  = 1'b0;
    endtask

    task automatic expect_spacing(input string req, input int ratio, input logic [2:0] code);
        int k;
        wait_pulse();
        for (int i = 0; i < 2; i++) begin
            gap(k);
            check(k == ratio, req, k, ratio);
        end
        check(eff_mode == code, req, eff_mode, code);
    endtask

    // R1: reset state and first pulse timing
    task automatic t_reset();
        int k;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(eff_mode == 3'b100, "R1", eff_mode, 3'b100);
        check(bclk_en == 1'b0, "R1", bclk_en, 0);
        @(negedge clk);
        rst_n = 1'b1;
        gap(k);
        check(k == 7, "R1", k, 7);
        gap(k);
        check(k == 8, "R1", k, 8);
    endtask

    // R2, R5: every field code
    task automatic t_modes();
        osc_stable = 1'b1;
        write_mode(3'b001); expect_spacing("R2", 2, 3'b001);
        write_mode(3'b010); expect_spacing("R2", 4, 3'b010);
        write_mode(3'b011); expect_spacing("R2", 16, 3'b011);
        write_mode(3'b111); expect_spacing("R2", 8, 3'b100);
        write_mode(3'b010); expect_spacing("R5", 4, 3'b010);
        write_mode(3'b101); expect_spacing("R2", 8, 3'b100);
    endtask

    // R3: no division
    task automatic t_nodiv();
        write_mode(3'b000);
        wait_pulse();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(bclk_en == 1'b1, "R3", bclk_en, 1);
        end
        check(eff_mode == 3'b000, "R3", eff_mode, 0);
    endtask

    // R4, R5: write mid-period waits for the boundary
    task automatic t_boundary();
        int k;
        write_mode(3'b011);
        expect_spacing("R4", 16, 3'b011);
        k = 0;
        @(negedge clk); k++;
        mode_sel = 3'b001; mode_wr = 1'b1;
        @(negedge clk); k++;
        mode_wr = 1'b0;
        check(eff_mode == 3'b011, "R5", eff_mode, 3'b011);
        while (!bclk_en) begin @(negedge clk); k++; end
        check(k == 16, "R4", k, 16);
        gap(k);
        check(k == 2, "R4", k, 2);
        check(eff_mode == 3'b001, "R4", eff_mode, 3'b001);
    endtask

    // R7: exit from divide-by-8 blocked until oscillator stable
    task automatic t_blocked();
        int k;
        osc_stable = 1'b1;
        write_mode(3'b100); expect_spacing("R7", 8, 3'b100);
        osc_stable = 1'b0;
        write_mode(3'b001);
        wait_pulse();
        for (int i = 0; i < 3; i++) begin
            gap(k);
            check(k == 8, "R7", k, 8);
        end
        check(eff_mode == 3'b100, "R7", eff_mode, 3'b100);
        osc_stable = 1'b1;
        expect_spacing("R7", 2, 3'b001);
    endtask

    // R6, R8: stop entry forces divide-by-8
    task automatic t_stop();
        write_mode(3'b010); expect_spacing("R6", 4, 3'b010);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        expect_spacing("R6", 8, 3'b100);
        expect_spacing("R6", 8, 3'b100);
        osc_stable = 1'b0;
        write_mode(3'b010);
        expect_spacing("R7", 8, 3'b100);
        osc_stable = 1'b1;
        expect_spacing("R6", 4, 3'b010);
        mode_sel = 3'b001; mode_wr = 1'b1; stop_req = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0; stop_req = 1'b0;
        expect_spacing("R8", 8, 3'b100);
    endtask

    initial begin
        #(20ns * 150000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_modes();
        t_nodiv();
        t_boundary();
        t_blocked();
        t_stop();
        write_mode(3'b000);
        wait_pulse();
        t_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule